// File: doc/BRIEF.md
# BFloat16 Widening Fused Multiply-Accumulate Unit

This unit multiplies half-width BFloat16 values by one broadcast BFloat16 scalar and adds each product into a single-precision accumulator lane. One rounding is applied to the whole sum. The first source is a 128-bit word of eight 16-bit lanes. A selector chooses either the even lanes or the odd lanes of that word. The second source is a 64-bit word of four 16-bit lanes, and a 2-bit index picks one of them as the common multiplier. Both factors are widened to single precision by appending sixteen zero bits. Each of the four 32-bit accumulator lanes then receives `acc + a*b`, rounded once to nearest-even.

A single fused datapath serves the four lanes in order, lane 0 first, one lane per clock. A `start` pulse launches an operation. `busy` stays high while the lanes run, and `done` pulses once the full 128-bit result is ready. Exceptions from every lane OR into five sticky flags, which stay set until `clr_flags` is raised. Two register-number inputs are checked when `start` is accepted: the destination number and the first-source number must both be even. If either is odd, the operation is refused.

The arithmetic runs in one fixed standard mode. Any NaN result is the default quiet NaN. Subnormal operands are treated as signed zeros, and results too small for the normal range are flushed to signed zero.

Top module: `bf16_wfma`

## Requirements
- R1: Result lane e (bits 32e+31..32e) takes its first factor from 16-bit element 2e+`sel_odd` of `src_a`, where element k is `src_a[16k+15:16k]`.
- R2: The second factor is element `scalar_idx` of `src_b` (bits 16i+15..16i). The same element is used for all four lanes.
- R3: Each factor is widened as `{bf16, 16'h0000}`. The lane result is the exact value of acc + a*b, rounded once to nearest with ties to even. Inexact (flag bit 3) is set when this rounding changes the value.
- R4: If any of the three lane operands is a NaN (exponent all ones, fraction nonzero), the result is 0x7FC00000. Invalid (flag bit 0) is set only when one of those NaNs is signalling, meaning its fraction MSB (bit 22) is 0. If no NaN is present, 0×∞ gives 0x7FC00000 with invalid set, and so does an infinite product added to an infinite addend of opposite sign.
- R5: A rounded result with biased exponent of 255 or more becomes an infinity of the result's sign, and sets overflow (bit 1) and inexact (bit 3).
- R6: An operand with exponent 0 counts as a zero of its own sign. If its fraction is nonzero, input-denormal (bit 4) is set. A nonzero exact result whose normalized biased exponent is below 1 before rounding becomes a zero of its sign and sets underflow (bit 2) only.
- R7: An exact zero sum is −0 only when the product and the addend are both negative zeros; in every other case it is +0. A zero product leaves a normal addend unchanged and raises no flag.
- R8: The five flags set by the lanes (bits [4:0] = input-denormal, inexact, underflow, overflow, invalid) accumulate into `flags` and stay set until `clr_flags` is high at a clock edge. If a clear and a lane's flags arrive at the same edge, the old bits are cleared and that lane's bits are kept.
- R9: After reset, `busy`, `done`, `undef`, `flags` and `result` are 0. A `start` accepted while idle gives `busy` high for exactly four cycles, lanes 0 to 3 are written in order, and `done` is high for the one cycle after that. `result` changes only while `busy` is high.
- R10: A `start` raised while `busy` is high has no effect on the running operation or on its result.
- R11: If `dst_reg[0]` or `src1_reg[0]` is 1 when an idle unit sees `start`, then `undef` is high for one cycle. No lane runs, `done` does not pulse, and `result` and `flags` are not changed by the refused operation.
- R12: If no case of R4 applies, an infinite product or an infinite addend produces an infinity of that operand's sign, with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an operation when idle |
| sel_odd | input | 1 | 0 selects even lanes of `src_a`, 1 selects odd lanes |
| scalar_idx | input | 2 | Index of the broadcast element in `src_b` |
| dst_reg | input | 5 | Destination register number, must be even |
| src1_reg | input | 5 | First-source register number, must be even |
| src_a | input | 128 | Eight BFloat16 values |
| src_b | input | 64 | Four BFloat16 values |
| acc | input | 128 | Four single-precision addends |
| clr_flags | input | 1 | Clears the sticky flags at the clock edge |
| busy | output | 1 | Lanes in progress |
| done | output | 1 | One-cycle pulse when the result is complete |
| undef | output | 1 | One-cycle pulse when an operation is refused |
| result | output | 128 | Four single-precision results |
| flags | output | 5 | Sticky exception flags |

## Verification
A flag clear and a lane's fresh exception bits can arrive at the same clock edge. The unit must drop the old bits and keep the new ones. The bench provokes this by raising `clr_flags` for one cycle in the middle of an operation whose lanes all round inexactly, and once more while the unit is idle. A behavioural per-cycle model decides which bits must survive at every edge. A second overlap, a `start` raised while lanes are still running, is judged the same way: the model expects the running result to be untouched.

// File: rtl/bf16wfma_pkg.sv
package bf16wfma_pkg;
  localparam int FLAG_W = 5;
  localparam int F_IO = 0;  // invalid operation
  localparam int F_OF = 1;  // overflow
  localparam int F_UF = 2;  // underflow (flushed)
  localparam int F_IX = 3;  // inexact
  localparam int F_ID = 4;  // input denormal
  localparam logic [31:0] QNAN_DEF = 32'h7FC0_0000;

  function automatic logic sp_is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic logic sp_is_inf(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] == 23'd0);
  endfunction

  function automatic logic sp_is_sub(input logic [31:0] x);
    return (x[30:23] == 8'h00) && (x[22:0] != 23'd0);
  endfunction
endpackage

// File: rtl/bf16w_pick.sv
module bf16w_pick #(
  parameter int LANES = 4,
  parameter int EW    = 16
) (
  input  logic [2*LANES*EW-1:0]     src_a,
  input  logic [LANES*EW-1:0]       src_b,
  input  logic                      sel_odd,
  input  logic [$clog2(LANES)-1:0]  scalar_idx,
  output logic [LANES*32-1:0]       a_wide,
  output logic [31:0]               b_wide
);
  localparam int PADW = 32 - EW;

  // R1: even or odd half-width lane feeds each 32-bit lane
  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [EW-1:0] elem;
    assign elem = sel_odd ? src_a[(2*e+1)*EW +: EW] : src_a[(2*e)*EW +: EW];
    assign a_wide[e*32 +: 32] = {elem, {PADW{1'b0}}};
  end

  // R2: broadcast scalar, widened by zero fill (R3)
  assign b_wide = {src_b[scalar_idx*EW +: EW], {PADW{1'b0}}};
endmodule

// File: rtl/bf16w_fma_core.sv
module bf16w_fma_core
  import bf16wfma_pkg::*;
(
  input  logic [31:0]       op_a,
  input  logic [31:0]       op_b,
  input  logic [31:0]       op_c,
  output logic [31:0]       res,
  output logic [FLAG_W-1:0] flg
);
  localparam int SW   = 52;  // working width: 3 integer bits + 49 fraction bits
  localparam int FRAC = 49;

  // Right shift keeping lost bits as a sticky LSB
  function automatic logic [SW-1:0] shr_st(input logic [SW-1:0] v, input int sh);
    logic [SW-1:0] r;
    if (sh >= SW) begin
      r = '0;
      r[0] = |v;
    end else begin
      r = v >> sh;
      r[0] = r[0] | (|(v & ~({SW{1'b1}} << sh)));
    end
    return r;
  endfunction

  logic          a_z, b_z, c_z, a_i, b_i, c_i, pz, sp, sc, s;
  logic [15:0]   pm;
  logic [SW-1:0] psig, csig, xp, xc, sum, nrm;
  logic [23:0]   mant;
  logic [24:0]   m2;
  logic          g, st, rnd;
  int            pe, ce, lexp, p, ex, ex2;

  always_comb begin
    res  = '0;
    flg  = '0;
    a_z  = (op_a[30:23] == 8'h00);
    b_z  = (op_b[30:23] == 8'h00);
    c_z  = (op_c[30:23] == 8'h00);
    a_i  = sp_is_inf(op_a);
    b_i  = sp_is_inf(op_b);
    c_i  = sp_is_inf(op_c);
    sp   = op_a[31] ^ op_b[31];
    sc   = op_c[31];
    pz   = a_z | b_z;
    pm   = 16'({1'b1, op_a[22:16]}) * 16'({1'b1, op_b[22:16]});
    pe   = int'(op_a[30:23]) + int'(op_b[30:23]) - 127;
    ce   = int'(op_c[30:23]);
    psig = pz  ? '0 : {1'b0, pm, 35'd0};
    csig = c_z ? '0 : {2'b00, 1'b1, op_c[22:0], 26'd0};
    xp = '0; xc = '0; sum = '0; nrm = '0; mant = '0; m2 = '0;
    g = 1'b0; st = 1'b0; rnd = 1'b0; s = 1'b0;
    lexp = 0; p = 0; ex = 0; ex2 = 0;
    flg[F_ID] = sp_is_sub(op_a) | sp_is_sub(op_b) | sp_is_sub(op_c);  // R6

    if (sp_is_nan(op_a) | sp_is_nan(op_b) | sp_is_nan(op_c)) begin  // R4
      res = QNAN_DEF;
      flg[F_IO] = (sp_is_nan(op_a) & ~op_a[22]) | (sp_is_nan(op_b) & ~op_b[22]) |
                  (sp_is_nan(op_c) & ~op_c[22]);
    end else if ((a_i & b_z) | (a_z & b_i)) begin
      res = QNAN_DEF;
      flg[F_IO] = 1'b1;
    end else if ((a_i | b_i) & c_i & (sp != sc)) begin
      res = QNAN_DEF;
      flg[F_IO] = 1'b1;
    end else if (a_i | b_i) begin  // R12
      res = {sp, 8'hFF, 23'd0};
    end else if (c_i) begin
      res = {sc, 8'hFF, 23'd0};
    end else begin
      // alignment to the larger exponent
      if (pz) begin
        lexp = ce; xc = csig; xp = '0;
      end else if (c_z) begin
        lexp = pe; xp = psig; xc = '0;
      end else if (pe >= ce) begin
        lexp = pe; xp = psig; xc = shr_st(csig, pe - ce);
      end else begin
        lexp = ce; xc = csig; xp = shr_st(psig, ce - pe);
      end
      if (sp == sc) begin
        sum = xp + xc; s = sp;
      end else if (xp >= xc) begin
        sum = xp - xc; s = sp;
      end else begin
        sum = xc - xp; s = sc;
      end
      if (sum == '0) begin  // R7
        res = {sp & sc, 31'd0};
      end else begin
        for (int k = 0; k < SW; k++) if (sum[k]) p = k;
        ex = lexp + p - FRAC;
        if (ex < 1) begin  // R6 flush
          res = {s, 31'd0};
          flg[F_UF] = 1'b1;
        end else begin
          nrm  = sum << (SW - 1 - p);
          mant = nrm[SW-1 -: 24];
          g    = nrm[SW-25];
          st   = |nrm[SW-26:0];
          rnd  = g & (st | mant[0]);  // R3 ties to even
          m2   = {1'b0, mant} + {24'd0, rnd};
          ex2  = ex + int'(m2[24]);
          if (ex2 >= 255) begin  // R5
            res = {s, 8'hFF, 23'd0};
            flg[F_OF] = 1'b1;
            flg[F_IX] = 1'b1;
          end else begin
            res = {s, 8'(ex2), m2[24] ? 23'd0 : m2[22:0]};
            flg[F_IX] = g | st;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bf16_wfma.sv
module bf16_wfma
  import bf16wfma_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EW    = 16,
  parameter int RW    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      sel_odd,
  input  logic [$clog2(LANES)-1:0]  scalar_idx,
  input  logic [RW-1:0]             dst_reg,
  input  logic [RW-1:0]             src1_reg,
  input  logic [2*LANES*EW-1:0]     src_a,
  input  logic [LANES*EW-1:0]       src_b,
  input  logic [LANES*32-1:0]       acc,
  input  logic                      clr_flags,
  output logic                      busy,
  output logic                      done,
  output logic                      undef,
  output logic [LANES*32-1:0]       result,
  output logic [FLAG_W-1:0]         flags
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int VW = LANES * 32;

  logic [VW-1:0]     pick_a, aw_q, c_q, res_q;
  logic [31:0]       pick_b, bw_q, core_res;
  logic [FLAG_W-1:0] core_flg, flags_q;
  logic [LW-1:0]     lane_q;
  logic              busy_q, done_q, undef_q;

  // named events
  logic bad_regs, op_accept, op_reject, lane_fire, last_lane;
  assign bad_regs  = dst_reg[0] | src1_reg[0];
  assign op_accept = start & ~busy_q & ~bad_regs;
  assign op_reject = start & ~busy_q & bad_regs;
  assign lane_fire = busy_q;
  assign last_lane = busy_q && (lane_q == LW'(LANES - 1));

  bf16w_pick #(.LANES(LANES), .EW(EW)) pick_i (
    .src_a(src_a), .src_b(src_b), .sel_odd(sel_odd), .scalar_idx(scalar_idx),
    .a_wide(pick_a), .b_wide(pick_b)
  );

  bf16w_fma_core core_i (
    .op_a(aw_q[lane_q*32 +: 32]), .op_b(bw_q), .op_c(c_q[lane_q*32 +: 32]),
    .res(core_res), .flg(core_flg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_q <= '0; bw_q <= '0; c_q <= '0; res_q <= '0; flags_q <= '0;
      lane_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; undef_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      flags_q <= (clr_flags ? '0 : flags_q) | (lane_fire ? core_flg : '0);  // R8
      if (lane_fire) begin
        res_q[lane_q*32 +: 32] <= core_res;
        lane_q <= lane_q + 1'b1;
        if (last_lane) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (op_accept) begin
        busy_q <= 1'b1;
        lane_q <= '0;
        aw_q   <= pick_a;
        bw_q   <= pick_b;
        c_q    <= acc;
      end else if (op_reject) begin
        undef_q <= 1'b1;  // R11
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign undef  = undef_q;
  assign result = res_q;
  assign flags  = flags_q;

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_lane |=> done_q);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(res_q));
  p_lane_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_lane) |=> (busy_q && lane_q == $past(lane_q) + 1'b1));
  p_refuse_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |=> (undef_q && !busy_q && !done_q));
  p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  p_default_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sp_is_nan(core_res)) |-> (core_res == QNAN_DEF));
  p_ovf_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && core_flg[F_OF]) |-> (core_flg[F_IX] && core_res[30:0] == 31'h7F80_0000));
endmodule

// File: tb/bf16_wfma_tb_top.sv
module bf16_wfma_tb_top;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, sel_odd = 1'b0, clr_flags = 1'b0;
  logic [1:0]   scalar_idx = '0;
  logic [4:0]   dst_reg = '0, src1_reg = '0;
  logic [127:0] src_a = '0, acc = '0;
  logic [63:0]  src_b = '0;
  logic busy, done, undef;
  logic [127:0] result;
  logic [4:0]   flags;

  bf16_wfma dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_odd(sel_odd), .scalar_idx(scalar_idx),
    .dst_reg(dst_reg), .src1_reg(src1_reg), .src_a(src_a), .src_b(src_b), .acc(acc),
    .clr_flags(clr_flags), .busy(busy), .done(done), .undef(undef),
    .result(result), .flags(flags)
  );

  int total = 0, bad = 0;
  string cur_req = "R9";
  bit finished = 1'b0;

  task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // exact reference: fixed point with 300 fraction bits, one rounding
  function automatic void ref_fma(input logic [31:0] a, input logic [31:0] b,
                                  input logic [31:0] c, output logic [31:0] r,
                                  output logic [4:0] f);
    logic [599:0] mp, mc, mag, one, msk;
    logic [24:0]  mant;
    bit an, bn, cn, ai, bi, ci, az, bz, cz, pneg, rneg, g, st;
    int msb, ex, sh;
    f = '0; r = '0;
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    cn = (c[30:23] == 8'hFF) && (c[22:0] != 0);
    ai = (a[30:23] == 8'hFF) && !an;
    bi = (b[30:23] == 8'hFF) && !bn;
    ci = (c[30:23] == 8'hFF) && !cn;
    az = a[30:23] == 0; bz = b[30:23] == 0; cz = c[30:23] == 0;
    if (az && a[22:0] != 0) f[4] = 1'b1;
    if (bz && b[22:0] != 0) f[4] = 1'b1;
    if (cz && c[22:0] != 0) f[4] = 1'b1;
    pneg = a[31] ^ b[31];
    if (an || bn || cn) begin
      r = 32'h7FC00000;
      if ((an && !a[22]) || (bn && !b[22]) || (cn && !c[22])) f[0] = 1'b1;
      return;
    end
    if ((ai && bz) || (az && bi) || ((ai || bi) && ci && pneg != c[31])) begin
      r = 32'h7FC00000; f[0] = 1'b1; return;
    end
    if (ai || bi) begin r = {pneg, 8'hFF, 23'd0}; return; end
    if (ci) begin r = {c[31], 8'hFF, 23'd0}; return; end
    mp = '0; mc = '0;
    if (!az && !bz) begin
      mp = 600'(16'({1'b1, a[22:16]}) * 16'({1'b1, b[22:16]}));
      mp = mp << (int'(a[30:23]) + int'(b[30:23]) + 32);
    end
    if (!cz) mc = 600'({1'b1, c[22:0]}) << (int'(c[30:23]) + 150);
    if (pneg == c[31]) begin mag = mp + mc; rneg = pneg; end
    else if (mp >= mc) begin mag = mp - mc; rneg = pneg; end
    else begin mag = mc - mp; rneg = c[31]; end
    if (mag == 0) begin r = {pneg & c[31], 31'd0}; return; end
    msb = 0;
    for (int k = 0; k < 600; k++) if (mag[k]) msb = k;
    ex = msb - 300 + 127;
    if (ex < 1) begin r = {rneg, 31'd0}; f[2] = 1'b1; return; end
    sh = msb - 23;
    mant = {1'b0, 24'(mag >> sh)};
    g = mag[sh-1];
    one = 600'd1;
    msk = (one << (sh - 1)) - one;
    st = (mag & msk) != 0;
    if (g && (st || mant[0])) mant = mant + 25'd1;
    if (mant[24]) begin mant = mant >> 1; ex++; end
    if (ex >= 255) begin r = {rneg, 8'hFF, 23'd0}; f[1] = 1'b1; f[3] = 1'b1; return; end
    r = {rneg, 8'(ex), mant[22:0]};
    if (g || st) f[3] = 1'b1;
  endfunction

  // behavioural per-cycle model
  bit m_busy = 0, m_done = 0, m_undef = 0;
  int m_lane = 0;
  logic [4:0]  m_flags = '0;
  logic [31:0] m_res [4];
  logic [31:0] p_res [4];
  logic [4:0]  p_flg [4];

  always @(posedge clk) begin
    logic [4:0] nf;
    logic [31:0] wa, wb;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_undef = 0; m_lane = 0; m_flags = '0;
      for (int e = 0; e < 4; e++) m_res[e] = '0;
    end else begin
      nf = clr_flags ? 5'd0 : m_flags;
      m_done = 0; m_undef = 0;
      if (m_busy) begin
        m_res[m_lane] = p_res[m_lane];
        nf = nf | p_flg[m_lane];
        if (m_lane == 3) begin m_busy = 0; m_done = 1; end
        else m_lane++;
      end else if (start) begin
        if (dst_reg[0] || src1_reg[0]) m_undef = 1;
        else begin
          wb = {src_b[16*int'(scalar_idx) +: 16], 16'h0000};
          for (int e = 0; e < 4; e++) begin
            wa = {src_a[16*(2*e + int'(sel_odd)) +: 16], 16'h0000};
            ref_fma(wa, wb, acc[32*e +: 32], p_res[e], p_flg[e]);
          end
          m_busy = 1; m_lane = 0;
        end
      end
      m_flags = nf;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check(cur_req, "busy/done/undef", {125'd0, busy, done, undef},
            {125'd0, m_busy, m_done, m_undef});
      check(cur_req, "flags", {123'd0, flags}, {123'd0, m_flags});
      check(cur_req, "result", result, {m_res[3], m_res[2], m_res[1], m_res[0]});
    end
  end

  task automatic run_op(logic [127:0] a, logic [63:0] b, logic [127:0] c, logic s,
                        logic [1:0] ix, logic [4:0] dr, logic [4:0] sr);
    @(negedge clk);
    src_a = a; src_b = b; acc = c; sel_odd = s; scalar_idx = ix;
    dst_reg = dr; src1_reg = sr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_lane(string req, int lane, logic [31:0] exp);
    check(req, "lane value", {96'd0, result[32*lane +: 32]}, {96'd0, exp});
  endtask

  function automatic logic [15:0] rnd_bf16();
    logic [15:0] v;
    int k;
    k = int'($urandom % 16);
    v = {1'($urandom), 8'(112 + $urandom % 30), 7'($urandom)};
    if (k == 0) v = {1'($urandom), 15'd0};
    else if (k == 1) v = {1'($urandom), 8'hFF, 7'd0};
    else if (k == 2) v = {1'($urandom), 8'h00, 7'($urandom)};
    else if (k == 3) v = {1'b0, 8'hFF, 1'($urandom), 6'($urandom % 63 + 1)};
    return v;
  endfunction

  function automatic logic [31:0] rnd_sp();
    return {1'($urandom), 8'(100 + $urandom % 60), 23'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] ra, rc;
    logic [63:0]  rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", "reset outputs", {result, busy, done, undef, flags}, '0);

    // R1: even vs odd lanes, elements k -> value k+1
    cur_req = "R1";
    ra = {16'h4100, 16'h40E0, 16'h40C0, 16'h40A0, 16'h4080, 16'h4040, 16'h4000, 16'h3F80};
    run_op(ra, {4{16'h3F80}}, '0, 1'b0, 2'd0, 5'd2, 5'd4);
    chk_lane("R1", 1, 32'h40400000);
    run_op(ra, {4{16'h3F80}}, '0, 1'b1, 2'd1, 5'd2, 5'd4);
    chk_lane("R1", 1, 32'h40800000);

    // R2: scalar index broadcast
    cur_req = "R2";
    for (int i = 0; i < 4; i++)
      run_op({8{16'h3F80}}, {16'h4080, 16'h4040, 16'h4000, 16'h3F80}, '0, 1'b0, 2'(i), 5'd0, 5'd0);
    chk_lane("R2", 2, 32'h40800000);

    // R3: single rounding, ties to even
    cur_req = "R3";
    run_op({8{16'h3980}}, {4{16'h3980}}, {32'h3F800001, 32'h3F800000, 32'h3F800001, 32'h3F800000},
           1'b0, 2'd0, 5'd0, 5'd0);
    chk_lane("R3", 0, 32'h3F800000);
    chk_lane("R3", 1, 32'h3F800002);

    // R4: NaN handling
    cur_req = "R4";
    run_op({16'h3F80, 16'h7F81, 16'h3F80, 16'h7FC0, 16'h3F80, 16'h0000, 16'h3F80, 16'h7F80},
           {4{16'h3F80}}, {32'h0, 32'h0, 32'h0, 32'h3F800000}, 1'b0, 2'd0, 5'd0, 5'd0);
    chk_lane("R4", 3, 32'h7FC00000);
    run_op({8{16'h7F80}}, {4{16'h0000}}, '0, 1'b1, 2'd3, 5'd0, 5'd0);
    run_op({8{16'h7F80}}, {4{16'h3F80}}, {4{32'hFF800000}}, 1'b0, 2'd0, 5'd0, 5'd0);
    chk_lane("R4", 0, 32'h7FC00000);

    // R12: infinities pass through
    cur_req = "R12";
    run_op({8{16'hFF80}}, {4{16'h4000}}, {4{32'hFF800000}}, 1'b0, 2'd0, 5'd0, 5'd0);
    chk_lane("R12", 2, 32'hFF800000);

    // R5: overflow
    cur_req = "R5";
    run_op({8{16'h7F00}}, {4{16'hFF00}}, '0, 1'b0, 2'd0, 5'd0, 5'd0);
    chk_lane("R5", 0, 32'hFF800000);

    // R6: flush of tiny results and denormal inputs
    cur_req = "R6";
    run_op({8{16'h0080}}, {4{16'h0080}}, '0, 1'b0, 2'd0, 5'd0, 5'd0);
    chk_lane("R6", 0, 32'h00000000);
    run_op({8{16'h0001}}, {4{16'h3F80}}, {4{32'h40000000}}, 1'b0, 2'd0, 5'd0, 5'd0);
    chk_lane("R6", 1, 32'h40000000);
    run_op({8{16'h3F80}}, {4{16'h3F80}}, {4{32'h00400000}}, 1'b0, 2'd0, 5'd0, 5'd0);

    // R7: signed zeros and cancellation
    cur_req = "R7";
    run_op({16'h8000, 16'h8000, 16'h0000, 16'h3F80, 16'h0000, 16'h8000, 16'h8000, 16'h0000},
           {4{16'h3F80}}, {32'h80000000, 32'h3FC00000, 32'h80000000, 32'h80000000},
           1'b0, 2'd0, 5'd0, 5'd0);
    chk_lane("R7", 0, 32'h00000000);
    chk_lane("R7", 1, 32'h80000000);
    run_op({8{16'h3F80}}, {4{16'h3F80}}, {4{32'hBF800000}}, 1'b1, 2'd0, 5'd0, 5'd0);
    chk_lane("R7", 3, 32'h00000000);

    // R8: clear coinciding with a lane's flag update, then idle clear
    cur_req = "R8";
    @(negedge clk);
    src_a = {8{16'h3F81}}; src_b = {4{16'h3F81}}; acc = {4{32'h33800001}};
    sel_odd = 1'b0; scalar_idx = 2'd0; dst_reg = 5'd0; src1_reg = 5'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); clr_flags = 1'b1;
    @(negedge clk); clr_flags = 1'b0;
    repeat (5) @(negedge clk);
    check("R8", "flags kept after overlap", {123'd0, flags[3]}, {127'd0, 1'b1});
    clr_flags = 1'b1;
    @(negedge clk); clr_flags = 1'b0;
    check("R8", "flags after idle clear", {123'd0, flags}, '0);

    // R10: start while busy ignored
    cur_req = "R10";
    @(negedge clk);
    src_a = {8{16'h4000}}; src_b = {4{16'h4000}}; acc = {4{32'h3F800000}};
    dst_reg = 5'd0; src1_reg = 5'd0; start = 1'b1;
    @(negedge clk);
    src_a = {8{16'h4100}}; acc = '0;
    @(negedge clk);
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk_lane("R10", 3, 32'h40A00000);

    // R11: odd register numbers refused
    cur_req = "R11";
    run_op({8{16'h4040}}, {4{16'h4040}}, '0, 1'b0, 2'd0, 5'd3, 5'd0);
    chk_lane("R11", 0, 32'h40A00000);
    run_op({8{16'h4040}}, {4{16'h4040}}, '0, 1'b0, 2'd0, 5'd0, 5'd7);

    // R3: mixed random operands
    cur_req = "R3";
    for (int n = 0; n < 80; n++) begin
      for (int k = 0; k < 8; k++) ra[16*k +: 16] = rnd_bf16();
      for (int k = 0; k < 4; k++) rb[16*k +: 16] = rnd_bf16();
      for (int k = 0; k < 4; k++) rc[32*k +: 32] = rnd_sp();
      if (n % 5 == 0) rc[31:0] = 32'h0;
      run_op(ra, rb, rc, 1'($urandom), 2'($urandom), 5'd0, 5'd0);
      if (n % 7 == 0) begin
        @(negedge clk); clr_flags = 1'b1;
        @(negedge clk); clr_flags = 1'b0;
      end
    end

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule